// File: doc/BRIEF.md
# Root Port Error Status Collector

This block sits in a root port and collects the error messages that arrive from below it. Each message carries a two-bit severity code and a 16-bit requester source ID. The block keeps a root error status word, which records whether correctable, non-fatal and fatal messages have arrived. It also records whether more than one message of each class arrived, and whether the first uncorrectable message was fatal. The source ID of the first correctable message and of the first uncorrectable message are each latched in a field of their own.

An error command register holds three reporting enables, one per message class. The block raises the advanced error interrupt when a received class has its enable set. In level mode this is a line that follows the condition. In message mode it is a one-cycle notification carrying the interrupt message number. The notification fires only when the condition turns from false to true, whether a new message or a command write caused the change. The message number comes from an implementation input and appears read-only in the top five bits of the status word. Software clears status bits by writing ones to them.

Top module: `root_err_collector`

## Requirements
- R1: After reset, the status word, the command register, both source fields, the interrupt line and the notification valid are all zero.
- R2: Severity code 0 is a correctable message. If correctable-received (status bit 0) is clear, the message sets it and stores its source ID in the correctable source field. If bit 0 is already set, the message sets multiple-correctable (bit 1) and leaves the source field unchanged.
- R3: Severity codes 1 (non-fatal) and 2 (fatal) are uncorrectable. If uncorrectable-received (bit 2) is clear, the message sets it and stores its source ID in the uncorrectable source field. If bit 2 is already set, the message sets multiple-uncorrectable (bit 3) and leaves the field unchanged.
- R4: A fatal message sets fatal-received (bit 6), and a non-fatal message sets non-fatal-received (bit 5). A fatal message that arrives while bit 2 is clear also sets first-uncorrectable-fatal (bit 4).
- R5: Severity code 3, or any cycle without msg_valid, changes no status bit and no source field.
- R6: A write with wr_sel=1 clears each status bit 6..0 whose wr_data bit is 1 and leaves the others unchanged. If a clear and a message fall in the same cycle, the clear applies first. Status bits 26..7 read zero.
- R7: A write with wr_sel=0 loads the command register from wr_data[2:0]: bit 0 enables correctable, bit 1 non-fatal and bit 2 fatal. wr_data[6:3] have no effect on it.
- R8: Status bits 31..27 show the value that irq_num_in had one clock earlier. Writes do not change them.
- R9: In level mode (irq_mode_msg=0), irq_level_o is (bit0 AND cmd0) OR (bit5 AND cmd1) OR (bit6 AND cmd2), evaluated after each message, command write or clear.
- R10: In message mode, irq_msg_valid_o is high for one cycle exactly when that condition goes from false to true. A new message or a command write can cause this. irq_msg_num_o then holds the message number shown in the status word before that edge.
- R11: In message mode irq_level_o stays low. In level mode irq_msg_valid_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_mode_msg | input | 1 | 1 = message (edge) interrupt mode, 0 = level mode |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | Severity: 0 correctable, 1 non-fatal, 2 fatal, 3 none |
| msg_src | input | 16 | Requester source ID of the message |
| irq_num_in | input | 5 | Interrupt message number supplied by the implementation |
| wr_en | input | 1 | Software write strobe |
| wr_sel | input | 1 | 0 = command register, 1 = status (write-1-to-clear) |
| wr_data | input | 7 | Write data |
| status_o | output | 32 | Root error status word |
| cmd_o | output | 3 | Error command register |
| src_cor_o | output | 16 | First correctable source ID |
| src_unc_o | output | 16 | First uncorrectable source ID |
| irq_level_o | output | 1 | Level-mode interrupt line |
| irq_msg_valid_o | output | 1 | Message-mode notification, one cycle |
| irq_msg_num_o | output | 5 | Message number carried by the notification |

## Verification
Every result the block produces is registered exactly once. Status bits, source fields, the command register, the interrupt line and the notification all change at the first rising edge that samples the message or write. The message-number field likewise follows irq_num_in one edge later. The bench therefore drives each stimulus at a falling edge and compares all outputs with its own model at the next falling edge, one edge after the change. It sweeps both modes, all command values and every sequence of three severities, so that both rising-edge sources and the same-cycle clear ordering are each reached many times.

// File: rtl/root_err_pkg.sv
package root_err_pkg;

    typedef enum logic [1:0] {
        SEV_COR      = 2'd0,
        SEV_NONFATAL = 2'd1,
        SEV_FATAL    = 2'd2,
        SEV_NONE     = 2'd3
    } sev_e;

    // status bit positions (software decodes these)
    localparam int ST_COR_RCV      = 0;
    localparam int ST_MULTI_COR    = 1;
    localparam int ST_UNC_RCV      = 2;
    localparam int ST_MULTI_UNC    = 3;
    localparam int ST_FIRST_FATAL  = 4;
    localparam int ST_NONFATAL_RCV = 5;
    localparam int ST_FATAL_RCV    = 6;
    localparam int ST_W            = 7;

    // command bit positions
    localparam int CMD_COR      = 0;
    localparam int CMD_NONFATAL = 1;
    localparam int CMD_FATAL    = 2;
    localparam int CMD_W        = 3;

    typedef struct packed {
        logic is_cor;
        logic is_unc;
        logic is_fatal;
    } msg_class_t;

endpackage

// File: rtl/root_err_decode.sv
module root_err_decode
    import root_err_pkg::*;
(
    input  logic       valid,
    input  logic [1:0] sev,
    output msg_class_t cls
);
    sev_e sev_v;

    always_comb begin
        sev_v        = sev_e'(sev);
        cls          = '0;
        if (valid) begin
            unique case (sev_v)
                SEV_COR: begin
                    cls.is_cor = 1'b1;
                end
                SEV_NONFATAL: begin
                    cls.is_unc = 1'b1;
                end
                SEV_FATAL: begin
                    cls.is_unc   = 1'b1;
                    cls.is_fatal = 1'b1;
                end
                default: begin
                    cls = '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/root_err_status.sv
module root_err_status
    import root_err_pkg::*;
#(
    parameter int SRC_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  msg_class_t        cls,
    input  logic [SRC_W-1:0]  src,
    input  logic [ST_W-1:0]   clr_mask,
    output logic [ST_W-1:0]   bits_q,
    output logic [CMD_W-1:0]  rcv_d,
    output logic [SRC_W-1:0]  src_cor_q,
    output logic [SRC_W-1:0]  src_unc_q
);
    typedef struct packed {
        logic [ST_W-1:0]  bits;
        logic [SRC_W-1:0] scor;
        logic [SRC_W-1:0] sunc;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // write-1-to-clear is applied before any arriving message
        st_d.bits = st_q.bits & ~clr_mask;

        if (cls.is_cor) begin
            if (st_d.bits[ST_COR_RCV]) begin
                st_d.bits[ST_MULTI_COR] = 1'b1;
            end else begin
                st_d.scor = src;
            end
            st_d.bits[ST_COR_RCV] = 1'b1;
        end

        if (cls.is_unc) begin
            if (st_d.bits[ST_UNC_RCV]) begin
                st_d.bits[ST_MULTI_UNC] = 1'b1;
            end else begin
                st_d.sunc = src;
                if (cls.is_fatal) begin
                    st_d.bits[ST_FIRST_FATAL] = 1'b1;
                end
            end
            st_d.bits[ST_UNC_RCV] = 1'b1;
            if (cls.is_fatal) begin
                st_d.bits[ST_FATAL_RCV] = 1'b1;
            end else begin
                st_d.bits[ST_NONFATAL_RCV] = 1'b1;
            end
        end

        rcv_d            = '0;
        rcv_d[CMD_COR]      = st_d.bits[ST_COR_RCV];
        rcv_d[CMD_NONFATAL] = st_d.bits[ST_NONFATAL_RCV];
        rcv_d[CMD_FATAL]    = st_d.bits[ST_FATAL_RCV];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bits_q    = st_q.bits;
    assign src_cor_q = st_q.scor;
    assign src_unc_q = st_q.sunc;
endmodule

// File: rtl/root_err_irq.sv
module root_err_irq
    import root_err_pkg::*;
#(
    parameter int NUM_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_msg,
    input  logic              cmd_we,
    input  logic [CMD_W-1:0]  cmd_wdata,
    input  logic [CMD_W-1:0]  rcv_d,
    input  logic [NUM_W-1:0]  num_in,
    output logic [CMD_W-1:0]  cmd_q,
    output logic [NUM_W-1:0]  num_q,
    output logic              level_q,
    output logic              pulse_q,
    output logic [NUM_W-1:0]  pulse_num_q
);
    typedef struct packed {
        logic [CMD_W-1:0] cmd;
        logic [NUM_W-1:0] num;
        logic             cond;
        logic             level;
        logic             pv;
        logic [NUM_W-1:0] pn;
    } irq_t;

    irq_t ir_d, ir_q;

    always_comb begin
        ir_d       = ir_q;
        ir_d.num   = num_in;
        if (cmd_we) begin
            ir_d.cmd = cmd_wdata;
        end
        // one detector covers both message arrival and command writes
        ir_d.cond  = |(rcv_d & ir_d.cmd);
        ir_d.level = !mode_msg && ir_d.cond;
        ir_d.pv    = mode_msg && ir_d.cond && !ir_q.cond;
        ir_d.pn    = ir_d.pv ? ir_q.num : ir_q.pn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ir_q <= '0;
        end else begin
            ir_q <= ir_d;
        end
    end

    assign cmd_q       = ir_q.cmd;
    assign num_q       = ir_q.num;
    assign level_q     = ir_q.level;
    assign pulse_q     = ir_q.pv;
    assign pulse_num_q = ir_q.pn;
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
    import root_err_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int NUM_W  = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_mode_msg,
    input  logic              msg_valid,
    input  logic [1:0]        msg_sev,
    input  logic [SRC_W-1:0]  msg_src,
    input  logic [NUM_W-1:0]  irq_num_in,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ST_W-1:0]   wr_data,
    output logic [DATA_W-1:0] status_o,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [SRC_W-1:0]  src_cor_o,
    output logic [SRC_W-1:0]  src_unc_o,
    output logic              irq_level_o,
    output logic              irq_msg_valid_o,
    output logic [NUM_W-1:0]  irq_msg_num_o
);
    localparam int PAD_W = DATA_W - NUM_W - ST_W;

    msg_class_t       cls;
    logic [ST_W-1:0]  clr_mask;
    logic [ST_W-1:0]  bits_q;
    logic [CMD_W-1:0] rcv_d;
    logic [NUM_W-1:0] num_q;
    logic             cmd_we;

    assign clr_mask = (wr_en && wr_sel) ? wr_data : '0;
    assign cmd_we   = wr_en && !wr_sel;

    root_err_decode u_decode (
        .valid (msg_valid),
        .sev   (msg_sev),
        .cls   (cls)
    );

    root_err_status #(.SRC_W(SRC_W)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .cls       (cls),
        .src       (msg_src),
        .clr_mask  (clr_mask),
        .bits_q    (bits_q),
        .rcv_d     (rcv_d),
        .src_cor_q (src_cor_o),
        .src_unc_q (src_unc_o)
    );

    root_err_irq #(.NUM_W(NUM_W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_msg    (irq_mode_msg),
        .cmd_we      (cmd_we),
        .cmd_wdata   (wr_data[CMD_W-1:0]),
        .rcv_d       (rcv_d),
        .num_in      (irq_num_in),
        .cmd_q       (cmd_o),
        .num_q       (num_q),
        .level_q     (irq_level_o),
        .pulse_q     (irq_msg_valid_o),
        .pulse_num_q (irq_msg_num_o)
    );

    assign status_o = {num_q, {PAD_W{1'b0}}, bits_q};
endmodule

// File: rtl/root_err_checker.sv
module root_err_checker
    import root_err_pkg::*;
#(
    parameter int SRC_W  = 16,
    parameter int NUM_W  = 5,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_W-1:0]  irq_num_in,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [ST_W-1:0]   wr_data,
    input logic [DATA_W-1:0] status_o,
    input logic [CMD_W-1:0]  cmd_o,
    input logic [SRC_W-1:0]  src_cor_o,
    input logic [SRC_W-1:0]  src_unc_o,
    input logic              irq_level_o,
    input logic              irq_msg_valid_o
);
    logic seen_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_COR_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_COR_RCV] && !(wr_en && wr_sel && wr_data[ST_COR_RCV])) |=> $stable(src_cor_o)); // R2
    AST_MULTI_COR_WITH_RCV: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ST_MULTI_COR]) |-> status_o[ST_COR_RCV]); // R2
    AST_UNC_SRC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_UNC_RCV] && !(wr_en && wr_sel && wr_data[ST_UNC_RCV])) |=> $stable(src_unc_o)); // R3
    AST_FIRST_FATAL_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status_o[ST_FIRST_FATAL]) |-> (status_o[ST_FATAL_RCV] && status_o[ST_UNC_RCV])); // R4
    AST_NUM_TRACKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |=> status_o[DATA_W-1 -: NUM_W] == $past(irq_num_in)); // R8
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_valid_o |=> !irq_msg_valid_o); // R10
    AST_PULSE_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq_msg_valid_o |-> |(cmd_o & {status_o[ST_FATAL_RCV], status_o[ST_NONFATAL_RCV], status_o[ST_COR_RCV]})); // R10
    AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(irq_level_o && irq_msg_valid_o)); // R11
endmodule

bind root_err_collector root_err_checker #(
    .SRC_W(SRC_W), .NUM_W(NUM_W), .DATA_W(DATA_W)
) chk_i (
    .clk             (clk),
    .rst_n           (rst_n),
    .irq_num_in      (irq_num_in),
    .wr_en           (wr_en),
    .wr_sel          (wr_sel),
    .wr_data         (wr_data),
    .status_o        (status_o),
    .cmd_o           (cmd_o),
    .src_cor_o       (src_cor_o),
    .src_unc_o       (src_unc_o),
    .irq_level_o     (irq_level_o),
    .irq_msg_valid_o (irq_msg_valid_o)
);

// File: tb/root_err_collector_tb_top.sv
module root_err_collector_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_mode_msg = 1'b0;
    logic        msg_valid = 1'b0;
    logic [1:0]  msg_sev = 2'd0;
    logic [15:0] msg_src = 16'd0;
    logic [4:0]  irq_num_in = 5'd0;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [6:0]  wr_data = 7'd0;
    logic [31:0] status_o;
    logic [2:0]  cmd_o;
    logic [15:0] src_cor_o, src_unc_o;
    logic        irq_level_o, irq_msg_valid_o;
    logic [4:0]  irq_msg_num_o;

    int n_tests = 0;
    int n_fail  = 0;

    // bench model
    logic [6:0]  m_bits = '0;
    logic [15:0] m_scor = '0, m_sunc = '0;
    logic [2:0]  m_cmd = '0;
    logic [4:0]  m_num = '0, m_pn = '0;
    logic        m_cond = 1'b0, m_lvl = 1'b0, m_pv = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    root_err_collector dut_i (
        .clk(clk), .rst_n(rst_n), .irq_mode_msg(irq_mode_msg),
        .msg_valid(msg_valid), .msg_sev(msg_sev), .msg_src(msg_src),
        .irq_num_in(irq_num_in), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .status_o(status_o), .cmd_o(cmd_o), .src_cor_o(src_cor_o), .src_unc_o(src_unc_o),
        .irq_level_o(irq_level_o), .irq_msg_valid_o(irq_msg_valid_o),
        .irq_msg_num_o(irq_msg_num_o)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_update();
        logic [6:0] b;
        logic [2:0] c;
        logic       cond;
        b = m_bits;
        c = m_cmd;
        if (wr_en && wr_sel)  b = b & ~wr_data;
        if (wr_en && !wr_sel) c = wr_data[2:0];
        if (msg_valid && msg_sev == 2'd0) begin
            if (b[0]) b[1] = 1'b1; else m_scor = msg_src;
            b[0] = 1'b1;
        end else if (msg_valid && (msg_sev == 2'd1 || msg_sev == 2'd2)) begin
            if (b[2]) b[3] = 1'b1;
            else begin
                m_sunc = msg_src;
                if (msg_sev == 2'd2) b[4] = 1'b1;
            end
            b[2] = 1'b1;
            if (msg_sev == 2'd2) b[6] = 1'b1; else b[5] = 1'b1;
        end
        cond  = |({b[6], b[5], b[0]} & c);
        m_pv  = irq_mode_msg && cond && !m_cond;
        if (m_pv) m_pn = m_num;
        m_lvl  = !irq_mode_msg && cond;
        m_cond = cond;
        m_bits = b;
        m_cmd  = c;
        m_num  = irq_num_in;
    endtask

    task automatic compare(input string tag);
        logic [31:0] exp_st;
        exp_st = {m_num, 20'd0, m_bits};
        chk(status_o == exp_st, tag, status_o, exp_st);
        chk(cmd_o == m_cmd, "R7", {29'd0, cmd_o}, {29'd0, m_cmd});
        chk(src_cor_o == m_scor, "R2", {16'd0, src_cor_o}, {16'd0, m_scor});
        chk(src_unc_o == m_sunc, "R3", {16'd0, src_unc_o}, {16'd0, m_sunc});
        chk(irq_level_o == m_lvl, irq_mode_msg ? "R11" : "R9", {31'd0, irq_level_o}, {31'd0, m_lvl});
        chk(irq_msg_valid_o == m_pv, irq_mode_msg ? "R10" : "R11", {31'd0, irq_msg_valid_o}, {31'd0, m_pv});
        if (m_pv) chk(irq_msg_num_o == m_pn, "R10", {27'd0, irq_msg_num_o}, {27'd0, m_pn});
    endtask

    task automatic cycle(input string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        compare(tag);
        msg_valid = 1'b0;
        wr_en     = 1'b0;
    endtask

    task automatic send(input logic [1:0] sev, input logic [15:0] src, input string tag);
        msg_valid = 1'b1; msg_sev = sev; msg_src = src;
        cycle(tag);
    endtask

    task automatic write(input logic sel, input logic [6:0] d, input string tag);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        cycle(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        cycle("R1");

        irq_num_in = 5'h1B;
        cycle("R8");
        write(1'b1, 7'h7F, "R8");

        // R5: severity 3 ignored
        send(2'd3, 16'hDEAD, "R5");
        chk(status_o[6:0] == 7'd0, "R5", status_o, 32'd0);

        // R4: fatal first, then non-fatal
        send(2'd2, 16'h1234, "R4");
        chk(status_o[6:0] == 7'h54, "R4", {25'd0, status_o[6:0]}, 32'h54);
        send(2'd1, 16'h5678, "R4");
        chk(status_o[6:0] == 7'h7C, "R4", {25'd0, status_o[6:0]}, 32'h7C);

        // R6: partial clear, then clear with simultaneous message
        write(1'b1, 7'h14, "R6");
        chk(status_o[6:0] == 7'h68, "R6", {25'd0, status_o[6:0]}, 32'h68);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 7'h7F;
        send(2'd0, 16'hBEEF, "R6");
        chk(status_o[6:0] == 7'h01 && src_cor_o == 16'hBEEF, "R6", status_o, 32'hD800_0001);

        // R7: upper data bits do not reach command
        write(1'b0, 7'h7A, "R7");

        for (int mode = 0; mode < 2; mode++) begin
            for (int cmd = 0; cmd < 8; cmd++) begin
                for (int s = 0; s < 64; s++) begin
                    irq_mode_msg = mode[0];
                    irq_num_in   = 5'(s + cmd * 3);
                    write(1'b1, 7'h7F, "R6");
                    write(1'b0, 7'(cmd), "R7");
                    for (int k = 0; k < 3; k++) begin
                        send(2'((s >> (2 * k)) & 3), {8'(s), 5'(cmd), 3'(k)},
                             k == 0 ? "R2" : (k == 1 ? "R3" : "R4"));
                    end
                    write(1'b0, 7'(cmd ^ 7), "R10");
                    write(1'b1, 7'h55, "R6");
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule